// File: doc/BRIEF.md
# Register Access-Control Gate

The gate stands between a simple register bus (address, write strobe, read strobe, write data, read data) and the register file of a small battery-backed timekeeping peripheral. It holds two permission registers, one for writes and one for reads. Each has one bit per protected register, and bit i guards the register at address i. When the matching bit is clear, a write is dropped without effect and a read returns zero. Each such refused access raises a one-cycle `blocked` pulse.

Software can only lower a permission bit. A write to a permission register is merged as old AND new data, so a 1 in the data never raises a bit. Only the system reset brings the bits back to 1. A second reset input covers the backup-supply power-on and software resets of the peripheral. It clears the protected register bank but leaves both permission registers untouched. The protected registers are modelled here as a generic bank of data words.

Eight base registers are always present. Three counter registers (high, low, enable) exist only when the `HAS_CTR` parameter is set. Without them their permission bits read as zero and cannot be written, so every access to their addresses is refused.

Top module: `acg_gate`

## Requirements
- R1: After system reset both permission registers read 0x0000FFFF with `HAS_CTR`=1 (0x0000F8FF with `HAS_CTR`=0), and every present register can be read and written.
- R2: A write to protected address i (0..10) while write-permission bit i is 0 leaves that register unchanged.
- R3: A read of protected address i while read-permission bit i is 0 returns zero, even when the register holds a non-zero value.
- R4: A write to a permission register stores old AND wdata on the valid bits. A 1 never sets a cleared bit. Only the system reset restores it.
- R5: The domain reset (`dom_rst_n` low) clears every protected register to zero and leaves both permission registers unchanged.
- R6: Protected addresses 0..10 are interrupt-enable, lock, status, control, compensation, alarm, prescaler, seconds, counter-high, counter-low and counter-enable. Bit i of each permission register guards address i. The write-permission register sits at address 0xC and the read-permission register at 0xD.
- R7: With `HAS_CTR`=0, permission bits 10:8 read 0 and ignore writes, and accesses to addresses 8..10 are refused.
- R8: Permission-register bits 15:11 always read 1, and bits DW-1:16 always read 0.
- R9: Writes to the permission registers are never refused. Unmapped addresses (11, 14, 15) read zero and never raise `blocked`.
- R10: `rd_valid` and `rd_data` appear in the cycle after `rd_en`, whether or not the read is refused. `blocked` pulses in that same cycle for each refused read or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; resets everything |
| dom_rst_n | input | 1 | Domain reset (backup power-on or software), active low; clears the protected bank only |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DW | Read data (zero when refused) |
| blocked | output | 1 | One-cycle pulse for each refused access |

## Verification
The assertions assume the address is stable and known whenever a strobe is high. The permission-hold property on the domain reset only considers cycles with no bus write. The check on a discarded write is off when a domain reset lands in the following cycle, because that reset legitimately clears the word. The bench keeps to these limits: it changes strobes and both resets only on falling clock edges, and it asserts a reset only while both strobes are low.

// File: rtl/acg_pkg.sv
package acg_pkg;
   localparam int PERM_W     = 16;
   localparam int NUM_BASE   = 8;
   localparam int NUM_CTR    = 3;
   localparam int NUM_SLOT   = NUM_BASE + NUM_CTR;
   localparam int ADDR_WPERM = 12;
   localparam int ADDR_RPERM = 13;
   localparam logic [PERM_W-1:0] RSVD_ONES = 16'hF800;

   // Protected slot order: bit i of a permission register guards slot i
   typedef enum logic [3:0] {
      SLOT_IRQ_EN  = 4'd0,
      SLOT_LOCK    = 4'd1,
      SLOT_STATUS  = 4'd2,
      SLOT_CTRL    = 4'd3,
      SLOT_COMP    = 4'd4,
      SLOT_ALARM   = 4'd5,
      SLOT_PRESC   = 4'd6,
      SLOT_SECONDS = 4'd7,
      SLOT_CNT_HI  = 4'd8,
      SLOT_CNT_LO  = 4'd9,
      SLOT_CNT_EN  = 4'd10
   } slot_e;
endpackage

// File: rtl/acg_perm_reg.sv
module acg_perm_reg #(
   parameter int W = 16,
   parameter logic [W-1:0] KEEP = '1,
   parameter logic [W-1:0] FILL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] bits_q;

   // clear-only storage: a write can lower bits, never raise them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bits_q <= KEEP;
      else if (wr) bits_q <= bits_q & wdata & KEEP;
   end

   assign q = (bits_q & KEEP) | FILL;
endmodule

// File: rtl/acg_reg_bank.sv
module acg_reg_bank #(
   parameter int DW    = 32,
   parameter int NSLOT = 11,
   parameter int NLIVE = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSLOT-1:0]          we,
   input  logic [DW-1:0]             wdata,
   output logic [NSLOT-1:0][DW-1:0]  q
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i < NLIVE) begin : g_live
         logic [DW-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word_q <= '0;
            else if (we[i]) word_q <= wdata;
         end
         assign q[i] = word_q;
      end else begin : g_absent
         logic unused_we;
         assign unused_we = we[i];
         assign q[i] = '0;
      end
   end
endmodule

// File: rtl/acg_gate.sv
module acg_gate
   import acg_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 4,
   parameter bit HAS_CTR = 1'b1
) (
   input  logic          clk,
   input  logic          sys_rst_n,
   input  logic          dom_rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          blocked
);
   localparam int SW    = $clog2(NUM_SLOT);
   localparam int NLIVE = NUM_BASE + (HAS_CTR ? NUM_CTR : 0);
   localparam logic [PERM_W-1:0] VALID =
      (PERM_W'(1) << NLIVE) - PERM_W'(1);

   if (DW < PERM_W) begin : g_bad_dw
      $error("acg_gate: DW must be at least PERM_W");
   end
   if (AW < SW || (2 ** AW) <= ADDR_RPERM) begin : g_bad_aw
      $error("acg_gate: AW too small for the address map");
   end

   logic [PERM_W-1:0]           wperm, rperm;
   logic [NUM_SLOT-1:0][DW-1:0] bank_q;
   logic [NUM_SLOT-1:0]         slot_we;
   logic                        bank_rst_n;
   logic                        is_slot, is_wperm, is_rperm;
   logic [SW-1:0]               sel;
   logic                        wbit, rbit;
   logic [DW-1:0]               slot_word, rd_d;
   logic                        blk_d;

   assign sel      = addr[SW-1:0];
   assign is_slot  = (addr < AW'(NUM_SLOT));
   assign is_wperm = (addr == AW'(ADDR_WPERM));
   assign is_rperm = (addr == AW'(ADDR_RPERM));

   always_comb begin
      wbit      = 1'b0;
      rbit      = 1'b0;
      slot_word = '0;
      for (int i = 0; i < NUM_SLOT; i++) begin
         if (sel == SW'(i)) begin
            wbit      = wperm[i];
            rbit      = rperm[i];
            slot_word = bank_q[i];
         end
      end
   end

   acg_perm_reg #(.W(PERM_W), .KEEP(VALID), .FILL(RSVD_ONES)) u_wperm (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .wr    (wr_en && is_wperm),
      .wdata (wdata[PERM_W-1:0]),
      .q     (wperm)
   );

   acg_perm_reg #(.W(PERM_W), .KEEP(VALID), .FILL(RSVD_ONES)) u_rperm (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .wr    (wr_en && is_rperm),
      .wdata (wdata[PERM_W-1:0]),
      .q     (rperm)
   );

   always_comb begin
      for (int i = 0; i < NUM_SLOT; i++) begin
         slot_we[i] = wr_en && is_slot && (sel == SW'(i)) && wperm[i];
      end
   end

   assign bank_rst_n = sys_rst_n & dom_rst_n;

   acg_reg_bank #(.DW(DW), .NSLOT(NUM_SLOT), .NLIVE(NLIVE)) u_bank (
      .clk   (clk),
      .rst_n (bank_rst_n),
      .we    (slot_we),
      .wdata (wdata),
      .q     (bank_q)
   );

   always_comb begin
      rd_d = '0;
      if (is_slot)       rd_d = rbit ? slot_word : '0;
      else if (is_wperm) rd_d = DW'(wperm);
      else if (is_rperm) rd_d = DW'(rperm);
      blk_d = (wr_en && is_slot && !wbit) || (rd_en && is_slot && !rbit);
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         blocked  <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? rd_d : '0;
         blocked  <= blk_d;
      end
   end
endmodule

// File: rtl/acg_gate_chk.sv
module acg_gate_chk
   import acg_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 4,
   parameter bit HAS_CTR = 1'b1
) (
   input logic                        clk,
   input logic                        sys_rst_n,
   input logic                        dom_rst_n,
   input logic                        wr_en,
   input logic                        rd_en,
   input logic [AW-1:0]               addr,
   input logic                        rd_valid,
   input logic [DW-1:0]               rd_data,
   input logic                        blocked,
   input logic [PERM_W-1:0]           wperm,
   input logic [PERM_W-1:0]           rperm,
   input logic [NUM_SLOT-1:0][DW-1:0] bank_q
);
   localparam int NLIVE = NUM_BASE + (HAS_CTR ? NUM_CTR : 0);
   localparam logic [PERM_W-1:0] RST_VIEW =
      ((PERM_W'(1) << NLIVE) - PERM_W'(1)) | RSVD_ONES;

   logic          wbit_now, arm_q;
   logic [AW-1:0] idx_q;
   logic [DW-1:0] word_now, word_q, word_idx;

   always_comb begin
      wbit_now = 1'b0;
      word_now = '0;
      word_idx = '0;
      for (int i = 0; i < NUM_SLOT; i++) begin
         if (addr == AW'(i)) begin
            wbit_now = wperm[i];
            word_now = bank_q[i];
         end
         if (idx_q == AW'(i)) word_idx = bank_q[i];
      end
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         arm_q  <= 1'b0;
         idx_q  <= '0;
         word_q <= '0;
      end else begin
         arm_q  <= wr_en && (addr < AW'(NUM_SLOT)) && !wbit_now && dom_rst_n;
         idx_q  <= addr;
         word_q <= word_now;
      end
   end

   // R1
   reset_view_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(sys_rst_n) |-> (wperm == RST_VIEW && rperm == RST_VIEW));

   // R2
   discarded_write_chk: assert property (@(posedge clk)
      disable iff (!sys_rst_n || !dom_rst_n)
      arm_q |-> (word_idx == word_q));

   // R3
   refused_read_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (rd_valid && blocked) |-> (rd_data == '0));

   // R4
   perm_never_rises_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ((wperm & ~$past(wperm)) == '0) && ((rperm & ~$past(rperm)) == '0));

   // R5
   domain_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!dom_rst_n && !wr_en) |=> ($stable(wperm) && $stable(rperm)));

   // R10
   read_latency_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      rd_en |=> rd_valid);

   if (!HAS_CTR) begin : g_no_ctr
      // R7
      ctr_absent_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
         (wperm[NUM_SLOT-1:NUM_BASE] == '0) && (rperm[NUM_SLOT-1:NUM_BASE] == '0));
   end
endmodule

bind acg_gate acg_gate_chk #(.DW(DW), .AW(AW), .HAS_CTR(HAS_CTR)) u_chk (
   .clk       (clk),
   .sys_rst_n (sys_rst_n),
   .dom_rst_n (dom_rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .blocked   (blocked),
   .wperm     (wperm),
   .rperm     (rperm),
   .bank_q    (bank_q)
);

// File: tb/tb_acg_gate.sv
`timescale 1ns/1ps
module tb_acg_gate;
   import acg_pkg::*;

   logic        clk = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        dom_rst_n = 1'b1;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        rd_valid, blocked, rd_valid_nc, blocked_nc;
   logic [31:0] rd_data, rd_data_nc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acg_gate #(.DW(32), .AW(4), .HAS_CTR(1'b1)) dut (
      .clk(clk), .sys_rst_n(sys_rst_n), .dom_rst_n(dom_rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .blocked(blocked));

   acg_gate #(.DW(32), .AW(4), .HAS_CTR(1'b0)) dut_nc (
      .clk(clk), .sys_rst_n(sys_rst_n), .dom_rst_n(dom_rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rd_valid(rd_valid_nc), .rd_data(rd_data_nc), .blocked(blocked_nc));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d,
                         output logic b, output logic bn);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      b = blocked; bn = blocked_nc;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d, output logic b,
                         output logic v, output logic [31:0] dn, output logic bn);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data; b = blocked; v = rd_valid; dn = rd_data_nc; bn = blocked_nc;
   endtask

   logic [31:0] d, dn;
   logic        b, bn, v;

   task automatic t_reset;
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R1 write-perm reset", d, 32'h0000FFFF);
      chk("R1 write-perm reset no-ctr", dn, 32'h0000F8FF);
      bus_rd(4'(ADDR_RPERM), d, b, v, dn, bn);
      chk("R1 read-perm reset", d, 32'h0000FFFF);
      bus_rd(SLOT_CTRL, d, b, v, dn, bn);
      chk("R1 control reads zero", d, 32'h0);
      chk("R1 control not blocked", {31'b0, b}, 32'h0);
   endtask

   task automatic t_absent;
      bus_wr(SLOT_CNT_LO, 32'h0000_1234, b, bn);
      chk("R7 counter write allowed with counter", {31'b0, b}, 32'h0);
      chk("R7 counter write refused without counter", {31'b0, bn}, 32'h1);
      bus_rd(SLOT_CNT_LO, d, b, v, dn, bn);
      chk("R7 counter readback with counter", d, 32'h0000_1234);
      chk("R7 counter read zero without counter", dn, 32'h0);
      chk("R7 counter read refused without counter", {31'b0, bn}, 32'h1);
      bus_wr(4'(ADDR_WPERM), 32'hFFFF_FFFF, b, bn);
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R7 counter perm bits stay zero", dn, 32'h0000F8FF);
   endtask

   task automatic t_basic;
      bus_wr(SLOT_ALARM, 32'hA5A5_1234, b, bn);
      chk("R6 alarm write allowed", {31'b0, b}, 32'h0);
      bus_rd(SLOT_ALARM, d, b, v, dn, bn);
      chk("R6 alarm readback", d, 32'hA5A5_1234);
      chk("R10 rd_valid next cycle", {31'b0, v}, 32'h1);
   endtask

   task automatic t_wblock;
      bus_wr(4'(ADDR_WPERM), 32'h0000_07DF, b, bn);
      chk("R9 perm write never refused", {31'b0, b}, 32'h0);
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R8 reserved ones, upper zero", d, 32'h0000FFDF);
      bus_wr(SLOT_ALARM, 32'h0000_0BAD, b, bn);
      chk("R10 blocked pulse on refused write", {31'b0, b}, 32'h1);
      bus_rd(SLOT_ALARM, d, b, v, dn, bn);
      chk("R2 alarm kept old value", d, 32'hA5A5_1234);
      bus_wr(SLOT_PRESC, 32'h0000_0066, b, bn);
      bus_rd(SLOT_PRESC, d, b, v, dn, bn);
      chk("R6 neighbour prescaler still writable", d, 32'h0000_0066);
   endtask

   task automatic t_noset;
      bus_wr(4'(ADDR_WPERM), 32'hFFFF_FFFF, b, bn);
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R4 cleared bit not raised", d, 32'h0000FFDF);
      bus_wr(SLOT_ALARM, 32'h0000_0C0C, b, bn);
      chk("R4 alarm write still refused", {31'b0, b}, 32'h1);
   endtask

   task automatic t_rblock;
      bus_wr(SLOT_LOCK, 32'h0000_0077, b, bn);
      bus_wr(4'(ADDR_RPERM), 32'hFFFF_FFFD, b, bn);
      bus_rd(SLOT_LOCK, d, b, v, dn, bn);
      chk("R3 refused read returns zero", d, 32'h0);
      chk("R3 refused read blocked", {31'b0, b}, 32'h1);
      chk("R10 refused read still valid", {31'b0, v}, 32'h1);
      bus_wr(SLOT_LOCK, 32'h0000_0088, b, bn);
      chk("R3 write not affected by read perm", {31'b0, b}, 32'h0);
      bus_rd(SLOT_STATUS, d, b, v, dn, bn);
      chk("R3 status read not blocked", {31'b0, b}, 32'h0);
   endtask

   task automatic t_unmapped;
      bus_rd(4'd14, d, b, v, dn, bn);
      chk("R9 unmapped read zero", d, 32'h0);
      chk("R9 unmapped read not blocked", {31'b0, b}, 32'h0);
      bus_wr(4'd11, 32'h1111_1111, b, bn);
      chk("R9 unmapped write not blocked", {31'b0, b}, 32'h0);
   endtask

   task automatic t_domain;
      bus_wr(SLOT_SECONDS, 32'h0000_7777, b, bn);
      @(negedge clk); dom_rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk); dom_rst_n = 1'b1;
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R5 write perm survives domain reset", d, 32'h0000FFDF);
      bus_rd(4'(ADDR_RPERM), d, b, v, dn, bn);
      chk("R5 read perm survives domain reset", d, 32'h0000FFFD);
      bus_rd(SLOT_SECONDS, d, b, v, dn, bn);
      chk("R5 seconds cleared", d, 32'h0);
      bus_rd(SLOT_PRESC, d, b, v, dn, bn);
      chk("R5 prescaler cleared", d, 32'h0);
   endtask

   task automatic t_sysrst;
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk); sys_rst_n = 1'b1;
      bus_rd(4'(ADDR_WPERM), d, b, v, dn, bn);
      chk("R4 system reset restores write perm", d, 32'h0000FFFF);
      bus_wr(SLOT_ALARM, 32'h0000_0055, b, bn);
      bus_rd(SLOT_ALARM, d, b, v, dn, bn);
      chk("R1 alarm writable after system reset", d, 32'h0000_0055);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      sys_rst_n = 1'b1;
      t_reset();
      t_absent();
      t_basic();
      t_wblock();
      t_noset();
      t_rblock();
      t_unmapped();
      t_domain();
      t_sysrst();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule